// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A host pulses a start input. The controller then drives a trial code to an external DAC, samples a single comparator input once per clock, and settles one result bit per clock. It begins at the most significant bit and works down to bit 0, so a conversion always takes exactly `RES_BITS` clocks, whatever the input level.

While the conversion runs, a status line reads 0. It returns to 1 when the finished code has been captured in the result register. A serial output carries each bit in the cycle after it is decided, MSB first.

The result can be wider than the host bus. A high-part enable and a low-part enable each place one bus-wide slice of the result onto a registered data bus. An output-enable flag is high only while one of those reads is being served.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `conv_done` is 1, `result` is 0, `bus_oe` is 0 and `bus_data` is 0.
- R2: When `start` is 1 at a clock edge while `conv_done` is 1, `conv_done` reads 0 from the next cycle on. It stays 0 for exactly `RES_BITS` cycles and then returns to 1.
- R3: In the first busy cycle, `dac_code` has only its most significant bit set (2048 for 12 bits).
- R4: Bits are settled from MSB to LSB, one per clock. A trial bit is kept when `cmp_ge` is 1 (input at or above the trial DAC level) and cleared when it is 0. With an ideal comparator, the final code equals the input code, including 0 and the full-scale code.
- R5: `result` takes the new code in the cycle in which `conv_done` returns to 1. It holds that value until the next conversion completes.
- R6: A `start` seen while `conv_done` is 0 is ignored. The running conversion ends at its original time with its original result.
- R7: After each decision edge, `ser_valid` is 1 and `ser_bit` equals the bit just decided, MSB first. When no conversion is running, `ser_valid` is 0.
- R8: `hi_en` high at an edge makes the next cycle show `bus_oe` = 1 and `bus_data` = result bits above bit 7, zero-extended. For 12 bits, result bits 11..8 appear on bus bits 3..0 and bus bits 7..4 are 0. If both enables are high, the high part is served.
- R9: `lo_en` high alone at an edge makes the next cycle show `bus_oe` = 1 and `bus_data` = result bits 7..0.
- R10: A cycle that follows an edge with neither enable high shows `bus_oe` = 0 and `bus_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled at the clock edge |
| cmp_ge | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| dac_code | output | RES_BITS | Trial code driven to the external DAC |
| conv_done | output | 1 | 0 while converting, 1 when idle or finished |
| ser_bit | output | 1 | Most recently decided bit |
| ser_valid | output | 1 | `ser_bit` holds a bit decided at the last edge |
| result | output | RES_BITS | Last completed conversion code |
| hi_en | input | 1 | Read request for the upper result slice |
| lo_en | input | 1 | Read request for the lower result slice |
| bus_data | output | BUS_BITS | Registered read data, 0 when not enabled |
| bus_oe | output | 1 | Read data is being driven |

## Verification
The accepting edge makes `conv_done` fall and presents the MSB-only trial code one cycle later. The k-th following edge settles bit `RES_BITS-k`, which shows on the serial pins in the next cycle. The `RES_BITS`-th edge raises `conv_done` and loads `result` together. A byte read appears one cycle after its enable.

The bench changes inputs on falling edges. It samples each output on the falling edge that follows the rising edge where that output is due, and counts busy cycles one by one. A late, early or extended conversion therefore shows up as a mismatch. The DAC and comparator are modelled as a comparison of an integer input level with `dac_code`, and every expected code is derived from that level.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Mode of the read port for one cycle
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LOW  = 2'd1,
    RD_HIGH = 2'd2
  } rd_sel_t;

  function automatic rd_sel_t pick_read(input logic hi, input logic lo);
    if (hi)      return RD_HIGH;
    else if (lo) return RD_LOW;
    else         return RD_NONE;
  endfunction
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                accept,
  output logic                busy,
  output logic [RES_BITS-1:0] step
);
  localparam int CW = $clog2(RES_BITS + 1) + 1;

  logic [CW-1:0] busy_cnt;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step     <= '0;
      busy_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      step     <= {1'b1, {(RES_BITS-1){1'b0}}};
      busy_cnt <= '0;
    end else if (busy) begin
      step     <= step >> 1;
      busy_cnt <= busy_cnt + 1'b1;
      if (step[0]) busy <= 1'b0;
    end
  end

  // R2: at most one position under trial, and only while busy
  a_r2_step_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step) && (busy == (step != '0)));

  // R2: a busy period never lasts more than RES_BITS cycles
  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_cnt < CW'(RES_BITS));

  // R2: a busy period ends after exactly RES_BITS cycles
  a_r2_busy_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(busy_cnt) == CW'(RES_BITS - 1));

  // R6: a start seen while busy does not restart the pointer
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !step[0]) |=> !step[RES_BITS-1]);
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                busy,
  input  logic [RES_BITS-1:0] step,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] code,
  output logic [RES_BITS-1:0] result,
  output logic                ser_bit,
  output logic                ser_valid
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] settled;
  logic [RES_BITS-1:0] next_code;

  always_comb begin
    settled   = (code & ~step) | (cmp_ge ? step : '0);
    next_code = settled | (step >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      result    <= '0;
      ser_bit   <= 1'b0;
      ser_valid <= 1'b0;
    end else begin
      ser_valid <= busy;
      if (accept) begin
        code <= MSB_ONLY;
      end else if (busy) begin
        code    <= next_code;
        ser_bit <= cmp_ge;
        if (step[0]) result <= settled;
      end
    end
  end

  // R3: first busy cycle offers only the MSB as trial
  a_r3_first_trial: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> code == MSB_ONLY);

  // R5: result only moves at the end of a conversion
  a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(result));

  // R7: serial bit valid only after a busy cycle
  a_r7_ser_follows_busy: assert property (@(posedge clk) disable iff (rst)
    ser_valid |-> $past(busy));
endmodule

// File: rtl/sar_byte_port.sv
module sar_byte_port
  import sar_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int BUS_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RES_BITS-1:0] result,
  input  logic                hi_en,
  input  logic                lo_en,
  output logic [BUS_BITS-1:0] bus_data,
  output logic                bus_oe
);
  localparam int WIDE = 2 * BUS_BITS;

  logic [WIDE-1:0] wide;
  rd_sel_t         sel;

  generate
    if (RES_BITS == WIDE) begin : g_full
      assign wide = result;
    end else begin : g_pad
      assign wide = {{(WIDE-RES_BITS){1'b0}}, result};
    end
  endgenerate

  assign sel = pick_read(hi_en, lo_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data <= '0;
      bus_oe   <= 1'b0;
    end else begin
      unique case (sel)
        RD_HIGH: begin
          bus_data <= wide[WIDE-1:BUS_BITS];
          bus_oe   <= 1'b1;
        end
        RD_LOW: begin
          bus_data <= wide[BUS_BITS-1:0];
          bus_oe   <= 1'b1;
        end
        default: begin
          bus_data <= '0;
          bus_oe   <= 1'b0;
        end
      endcase
    end
  end

  // R10: the bus is quiet when no read is served
  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_data == '0);

  // R8: a read is served one cycle after an enable
  a_r8_oe_follows_enable: assert property (@(posedge clk) disable iff (rst)
    (hi_en || lo_en) |=> bus_oe);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int RES_BITS = 12,
  parameter int BUS_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] dac_code,
  output logic                conv_done,
  output logic                ser_bit,
  output logic                ser_valid,
  output logic [RES_BITS-1:0] result,
  input  logic                hi_en,
  input  logic                lo_en,
  output logic [BUS_BITS-1:0] bus_data,
  output logic                bus_oe
);
  logic                accept;
  logic                busy;
  logic [RES_BITS-1:0] step;

  sar_sequencer #(.RES_BITS(RES_BITS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .step   (step)
  );

  sar_register #(.RES_BITS(RES_BITS)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .busy      (busy),
    .step      (step),
    .cmp_ge    (cmp_ge),
    .code      (dac_code),
    .result    (result),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid)
  );

  sar_byte_port #(.RES_BITS(RES_BITS), .BUS_BITS(BUS_BITS)) u_port (
    .clk      (clk),
    .rst      (rst),
    .result   (result),
    .hi_en    (hi_en),
    .lo_en    (lo_en),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
  );

  assign conv_done = !busy;

  // R1: status is done during reset release
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> conv_done);
endmodule

// File: tb/sar_ctrl_test.sv
`timescale 1ns/1ps
module sar_ctrl_test;
  localparam int N = 12;
  localparam int B = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         hi_en = 1'b0;
  logic         lo_en = 1'b0;
  logic         cmp_ge;
  logic [N-1:0] dac_code;
  logic         conv_done;
  logic         ser_bit;
  logic         ser_valid;
  logic [N-1:0] result;
  logic [B-1:0] bus_data;
  logic         bus_oe;

  int vin = 0;
  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // behavioural DAC plus comparator
  assign cmp_ge = (vin >= int'(dac_code));

  sar_ctrl #(.RES_BITS(N), .BUS_BITS(B)) uut (
    .clk(clk), .rst(rst), .start(start), .cmp_ge(cmp_ge),
    .dac_code(dac_code), .conv_done(conv_done),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .result(result),
    .hi_en(hi_en), .lo_en(lo_en), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  function automatic int exp_hi(input int v);
    return (v >> B) & ((1 << B) - 1);
  endfunction

  function automatic int exp_lo(input int v);
    return v & ((1 << B) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // full conversion; optional stray start at busy cycle 'stray' (0 = none)
  task automatic convert(input int v, input int stray);
    int done_low;
    bit bits_ok;
    done_low = 0;
    bits_ok = 1'b1;
    @(negedge clk);
    vin = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(conv_done == 1'b0, "R2 done low after start", int'(conv_done), 0);
    chk(int'(dac_code) == (1 << (N-1)), "R3 first trial", int'(dac_code), 1 << (N-1));
    for (int i = 1; i <= N; i++) begin
      if (i == stray) start = 1'b1;
      if (!conv_done) done_low++;
      @(negedge clk);
      start = 1'b0;
      if (!(ser_valid && ser_bit == v[N-i])) bits_ok = 1'b0;
      if (i < N && conv_done) bits_ok = 1'b0;
    end
    chk(bits_ok, "R7 serial MSB-first bits", int'(ser_bit), v[0]);
    chk(done_low == N && conv_done, "R2 busy length", done_low, N);
    chk(int'(result) == v, stray != 0 ? "R6 start while busy ignored" : "R4 R5 result", int'(result), v);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R7 serial idle", int'(ser_valid), 0);
    chk(int'(result) == v, "R5 result held", int'(result), v);
  endtask

  task automatic rd(input bit h, input bit l, input int v);
    @(negedge clk);
    hi_en = h;
    lo_en = l;
    @(negedge clk);
    hi_en = 1'b0;
    lo_en = 1'b0;
    if (h) begin
      chk(bus_oe && int'(bus_data) == exp_hi(v), "R8 high part", int'(bus_data), exp_hi(v));
    end else begin
      chk(bus_oe && int'(bus_data) == exp_lo(v), "R9 low part", int'(bus_data), exp_lo(v));
    end
    @(negedge clk);
    chk(!bus_oe && bus_data == '0, "R10 bus quiet", int'(bus_data), 0);
  endtask

  initial begin
    int seed_dummy;
    int v;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(conv_done == 1'b1, "R1 done after reset", int'(conv_done), 1);
    chk(result == '0, "R1 result after reset", int'(result), 0);
    chk(!bus_oe && bus_data == '0, "R1 bus after reset", int'(bus_data), 0);

    convert(0, 0);
    rd(1'b0, 1'b1, 0);
    convert((1 << N) - 1, 0);
    rd(1'b1, 1'b0, (1 << N) - 1);
    rd(1'b0, 1'b1, (1 << N) - 1);
    rd(1'b1, 1'b1, (1 << N) - 1);
    convert(1 << (N-1), 0);
    convert((1 << (N-1)) - 1, 0);
    convert(12'hA5C, 5);
    rd(1'b1, 1'b0, 12'hA5C);
    rd(1'b0, 1'b1, 12'hA5C);
    convert(12'h3C1, N);
    for (int k = 0; k < 24; k++) begin
      v = int'($urandom % (1 << N));
      convert(v, (k % 4 == 0) ? 1 + (k % N) : 0);
      rd(1'b1, 1'b0, v);
      rd(1'b0, 1'b1, v);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule